// File: doc/BRIEF.md
# Interrupt Cause to Vector Router

This block gathers device interrupt events into two 32-bit cause registers: one for data-flow causes and one for general hardware causes. Every cause bit has a one-byte routing entry. The low seven bits of that entry pick a message-signalled vector. Bit 7 of the entry picks whether the cause clears itself when its vector fires or stays set until the host acknowledges it. Each cause register has its own mask register, and in that register a 1 blocks the cause.

When a vector fires, the block records it in an auto-mask status register. A vector whose status bit is set cannot fire again until the host writes 1 to that bit. This holds back nested requests while the host services the vector. Each firing appears at the vector output as a single-cycle pulse.

The host uses a 32-bit word port. Writes take effect at a clock edge and reads are combinational. The usual setup gives the receive-queue causes to the lower vectors and sends everything else to the last vector.

Top module: `irq_vector_router`

## Requirements
- R1: After reset, both cause registers read 0, both mask registers read 0xFFFFFFFF (all blocked), the auto-mask status reads 0, every routing byte reads 0, and `irq_o` is 0.
- R2: An event bit high on `flow_evt_i`/`hw_evt_i` at a clock edge sets the matching bit of the data-flow cause (address 0x00) or hardware cause (address 0x08) register. The bit is visible from the next cycle on.
- R3: Writing to a cause register clears exactly the bits written as 1. If an event for a bit arrives at the same edge as that clear, the event wins and the bit stays set.
- R4: In the masks (data-flow at 0x04, hardware at 0x0C), bit value 1 blocks a cause and 0 enables it. A blocked pending cause neither fires nor auto-clears. It fires once it is enabled.
- R5: Routing bytes live at byte address 0x80+e, four per word with the lowest address in bits 7:0. Data-flow bit b uses entry e=b and hardware bit b uses e=32+b. Bits 6:0 of the byte give the vector; a value of NUM_VEC or more reaches no vector.
- R6: A vector fires when an enabled pending cause is routed to it and its auto-mask bit is clear. `irq_o[v]` goes high in the cycle after the cause is first visible and stays high for exactly one cycle.
- R7: When a vector fires, its bit in the auto-mask status (address 0x10) is set and the vector cannot fire again. Writing 1 to the bit re-arms the vector, and a cause still pending then fires it one cycle later.
- R8: A routing byte with bit 7 = 0 (auto-clear) makes the cause clear at the edge its vector fires. With bit 7 = 1 the cause stays set until the host clears it.
- R9: Several causes routed to one vector produce a single pulse. Causes routed to different vectors fire those vectors in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flow_evt_i | input | 32 | Data-flow cause events, one per bit |
| hw_evt_i | input | 32 | Hardware cause events, one per bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | NUM_VEC | One-cycle vector request pulses |

## Verification
The hardest situation to reach is a host write-one-to-clear that lands at the same edge as a new event on the same cause bit. The bench drives the event and the clear write on the same falling edge, which puts both on the one rising edge. It then reads the register to confirm the bit survived. A cause routed to a vector number beyond the configured count is used here, so that no firing clears the bit in the meantime. A second hard case is a cause that becomes pending while its vector is auto-masked. The bench fires the vector, raises a second cause on that vector, confirms no pulse, then re-arms the vector and times the pulse that follows.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int CAUSE_W     = 32;
  localparam int ADDR_W      = 8;
  localparam int TBL_ENTRIES = 2 * CAUSE_W;
  localparam int TBL_WORDS   = TBL_ENTRIES / 4;
  localparam int TBL_IDX_W   = $clog2(TBL_WORDS);
  localparam int VSEL_W      = 7;

  localparam logic [ADDR_W-1:0] A_FLOW_CAUSE = 8'h00;
  localparam logic [ADDR_W-1:0] A_FLOW_MASK  = 8'h04;
  localparam logic [ADDR_W-1:0] A_HW_CAUSE   = 8'h08;
  localparam logic [ADDR_W-1:0] A_HW_MASK    = 8'h0C;
  localparam logic [ADDR_W-1:0] A_AUTOMASK   = 8'h10;
  localparam logic [1:0]        TBL_REGION   = 2'b10;  // addr[7:6]
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] auto_clr_i,
  output logic [W-1:0] cause_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] act_o
);
  logic [W-1:0] cause_q, mask_q, host_clr;

  assign host_clr = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '1;
    end else begin
      // new events override any clear in the same cycle
      cause_q <= (cause_q & ~host_clr & ~auto_clr_i) | evt_i;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign act_o   = cause_q & ~mask_q;
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_router_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [TBL_IDX_W-1:0]     widx_i,
  input  logic [31:0]              wdata_i,
  output logic [TBL_ENTRIES*8-1:0] tbl_o
);
  logic [TBL_ENTRIES*8-1:0] tbl_q;

  for (genvar w = 0; w < TBL_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tbl_q[w*32 +: 32] <= '0;
      else if (we_i && widx_i == TBL_IDX_W'(w)) tbl_q[w*32 +: 32] <= wdata_i;
    end
  end

  assign tbl_o = tbl_q;
endmodule

// File: rtl/irq_vec_engine.sv
module irq_vec_engine
  import irq_router_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int N_CAUSE = TBL_ENTRIES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_CAUSE-1:0]   act_i,
  input  logic [N_CAUSE*8-1:0] tbl_i,
  input  logic [NUM_VEC-1:0]   am_clr_i,
  output logic [NUM_VEC-1:0]   irq_o,
  output logic [NUM_VEC-1:0]   am_o,
  output logic [N_CAUSE-1:0]   auto_clr_o
);
  logic [N_CAUSE-1:0][NUM_VEC-1:0] sel;
  logic [N_CAUSE-1:0]              nac;
  logic [NUM_VEC-1:0]              req, fire, am_q, irq_q;

  for (genvar c = 0; c < N_CAUSE; c++) begin : g_dec
    logic [VSEL_W-1:0] vs;
    assign vs     = tbl_i[c*8 +: VSEL_W];
    assign nac[c] = tbl_i[c*8 + 7];
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_v
      assign sel[c][v] = (vs == VSEL_W'(v));
    end
  end

  always_comb begin
    req = '0;
    for (int c = 0; c < N_CAUSE; c++)
      req = req | (sel[c] & {NUM_VEC{act_i[c]}});
  end

  assign fire = req & ~am_q;

  always_comb begin
    for (int c = 0; c < N_CAUSE; c++)
      auto_clr_o[c] = act_i[c] & ~nac[c] & (|(sel[c] & fire));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      am_q  <= '0;
      irq_q <= '0;
    end else begin
      am_q  <= (am_q & ~am_clr_i) | fire;
      irq_q <= fire;
    end
  end

  assign irq_o = irq_q;
  assign am_o  = am_q;
endmodule

// File: rtl/irq_vector_router.sv
module irq_vector_router
  import irq_router_pkg::*;
#(
  parameter int NUM_VEC = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CAUSE_W-1:0]  flow_evt_i,
  input  logic [CAUSE_W-1:0]  hw_evt_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic [NUM_VEC-1:0]  irq_o
);
  logic [CAUSE_W-1:0]       flow_cause, flow_mask, flow_act;
  logic [CAUSE_W-1:0]       hw_cause, hw_mask, hw_act;
  logic [TBL_ENTRIES-1:0]   auto_clr;
  logic [TBL_ENTRIES*8-1:0] tbl;
  logic [NUM_VEC-1:0]       am, am_clr;
  logic                     tbl_hit;
  logic [TBL_IDX_W-1:0]     widx;

  assign tbl_hit = (reg_addr_i[7:6] == TBL_REGION) && (reg_addr_i[1:0] == 2'b00);
  assign widx    = reg_addr_i[2 +: TBL_IDX_W];
  assign am_clr  = (reg_we_i && reg_addr_i == A_AUTOMASK) ? reg_wdata_i[NUM_VEC-1:0] : '0;

  irq_cause_bank #(.W(CAUSE_W)) u_flow (
    .clk_i, .rst_ni,
    .evt_i     (flow_evt_i),
    .clr_we_i  (reg_we_i && reg_addr_i == A_FLOW_CAUSE),
    .mask_we_i (reg_we_i && reg_addr_i == A_FLOW_MASK),
    .wdata_i   (reg_wdata_i),
    .auto_clr_i(auto_clr[CAUSE_W-1:0]),
    .cause_o   (flow_cause),
    .mask_o    (flow_mask),
    .act_o     (flow_act)
  );

  irq_cause_bank #(.W(CAUSE_W)) u_hw (
    .clk_i, .rst_ni,
    .evt_i     (hw_evt_i),
    .clr_we_i  (reg_we_i && reg_addr_i == A_HW_CAUSE),
    .mask_we_i (reg_we_i && reg_addr_i == A_HW_MASK),
    .wdata_i   (reg_wdata_i),
    .auto_clr_i(auto_clr[TBL_ENTRIES-1:CAUSE_W]),
    .cause_o   (hw_cause),
    .mask_o    (hw_mask),
    .act_o     (hw_act)
  );

  irq_route_table u_tbl (
    .clk_i, .rst_ni,
    .we_i   (reg_we_i && tbl_hit),
    .widx_i (widx),
    .wdata_i(reg_wdata_i),
    .tbl_o  (tbl)
  );

  // cause index = routing entry: flow bits 0..31, hw bits 32..63
  irq_vec_engine #(.NUM_VEC(NUM_VEC), .N_CAUSE(TBL_ENTRIES)) u_vec (
    .clk_i, .rst_ni,
    .act_i     ({hw_act, flow_act}),
    .tbl_i     (tbl),
    .am_clr_i  (am_clr),
    .irq_o     (irq_o),
    .am_o      (am),
    .auto_clr_o(auto_clr)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_FLOW_CAUSE: reg_rdata_o = flow_cause;
      A_FLOW_MASK:  reg_rdata_o = flow_mask;
      A_HW_CAUSE:   reg_rdata_o = hw_cause;
      A_HW_MASK:    reg_rdata_o = hw_mask;
      A_AUTOMASK:   reg_rdata_o[NUM_VEC-1:0] = am;
      default:      if (tbl_hit) reg_rdata_o = tbl[widx*32 +: 32];
    endcase
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_VEC = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [31:0]        flow_evt_i,
  input logic [31:0]        hw_evt_i,
  input logic [31:0]        flow_cause_i,
  input logic [31:0]        hw_cause_i,
  input logic [31:0]        flow_act_i,
  input logic [31:0]        hw_act_i,
  input logic [NUM_VEC-1:0] am_i,
  input logic [NUM_VEC-1:0] irq_i
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;

  a_r6_one_cycle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> ((irq_i & $past(irq_i)) == '0));

  a_r7_fire_sets_automask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i & ~am_i) == '0);

  a_r7_masked_vector_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> ((irq_i & $past(am_i)) == '0));

  a_r3_event_wins_flow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> ((flow_cause_i & $past(flow_evt_i)) == $past(flow_evt_i)));

  a_r3_event_wins_hw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> ((hw_cause_i & $past(hw_evt_i)) == $past(hw_evt_i)));

  a_r4_fire_needs_enabled_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && irq_i != '0) |-> ($past(flow_act_i | hw_act_i) != '0));
endmodule

bind irq_vector_router irq_router_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flow_evt_i  (flow_evt_i),
  .hw_evt_i    (hw_evt_i),
  .flow_cause_i(flow_cause),
  .hw_cause_i  (hw_cause),
  .flow_act_i  (flow_act),
  .hw_act_i    (hw_act),
  .am_i        (am),
  .irq_i       (irq_o)
);

// File: tb/sim_irq_vector_router.sv
`timescale 1ns/1ps
module sim_irq_vector_router;
  localparam int NV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   flow_evt = '0, hw_evt = '0;
  logic          we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [NV-1:0] irq;
  int            nchk = 0, nfail = 0;
  bit            done = 1'b0;
  logic [7:0]    shadow [64];

  always #5 clk = ~clk;

  irq_vector_router #(.NUM_VEC(NV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .flow_evt_i(flow_evt), .hw_evt_i(hw_evt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic set_route(int e, logic [7:0] b);
    int w = e / 4;
    shadow[e] = b;
    wr(8'h80 + 8'(w*4), {shadow[w*4+3], shadow[w*4+2], shadow[w*4+1], shadow[w*4]});
  endtask

  // event at one edge; returns at the negedge where the cause is visible
  task automatic pulse(logic [31:0] f, logic [31:0] h);
    @(negedge clk); flow_evt = f; hw_evt = h;
    @(negedge clk); flow_evt = '0; hw_evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1 flow cause", d, 32'h0);
    rd(8'h04, d); chk("R1 flow mask", d, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R1 hw cause", d, 32'h0);
    rd(8'h0C, d); chk("R1 hw mask", d, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R1 automask", d, 32'h0);
    rd(8'hA4, d); chk("R1 route word", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_setup();
    logic [31:0] d;
    set_route(16, 8'h03);  // flow 16 -> v3 auto
    set_route(21, 8'h03);  // flow 21 -> v3 auto
    set_route(39, 8'h81);  // hw 7  -> v1 sticky
    set_route(61, 8'h05);  // hw 29 -> out of range
    set_route(32, 8'h02);  // hw 0  -> v2 auto
    wr(8'h04, ~32'h0021_0004);
    wr(8'h0C, ~32'h2000_0081);
    rd(8'h90, d); chk("R5 route word 16..19", d, 32'h0000_0003);
    rd(8'hA4, d); chk("R5 route word 36..39 lane 3", d, 32'h8100_0000);
  endtask

  task automatic t_autoclr();
    logic [31:0] d;
    pulse(32'h0001_0000, '0);
    rd(8'h00, d); chk("R2 flow cause set", d, 32'h0001_0000);
    chk("R6 no irq yet", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R6 irq v3", 32'(irq), 32'h8);
    rd(8'h00, d); chk("R8 auto-clear", d, 32'h0);
    rd(8'h10, d); chk("R7 automask set", d, 32'h8);
    @(negedge clk);
    chk("R6 single cycle", 32'(irq), 32'h0);
  endtask

  task automatic t_automask();
    logic [31:0] d;
    pulse(32'h0020_0000, '0);
    @(negedge clk); chk("R7 blocked", 32'(irq), 32'h0);
    @(negedge clk); chk("R7 still blocked", 32'(irq), 32'h0);
    rd(8'h00, d); chk("R7 cause held", d, 32'h0020_0000);
    wr(8'h10, 32'h8);
    chk("R7 rearm no irq yet", 32'(irq), 32'h0);
    @(negedge clk); chk("R7 fires after rearm", 32'(irq), 32'h8);
    rd(8'h00, d); chk("R8 cleared on refire", d, 32'h0);
    wr(8'h10, 32'h8);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse('0, 32'h0000_0080);
    @(negedge clk); chk("R8 sticky irq v1", 32'(irq), 32'h2);
    rd(8'h08, d); chk("R8 sticky cause stays", d, 32'h0000_0080);
    wr(8'h08, 32'h0000_0080);
    rd(8'h08, d); chk("R3 host clear", d, 32'h0);
    wr(8'h10, 32'h2);
    @(negedge clk); chk("R7 no refire without cause", 32'(irq), 32'h0);
    rd(8'h10, d); chk("R7 rearmed", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h04, ~32'h0021_0000);
    pulse(32'h0000_0004, '0);
    @(negedge clk); chk("R4 masked no irq", 32'(irq), 32'h0);
    @(negedge clk); chk("R4 masked no irq 2", 32'(irq), 32'h0);
    rd(8'h00, d); chk("R4 masked not cleared", d, 32'h0000_0004);
    wr(8'h04, ~32'h0021_0004);
    @(negedge clk); chk("R4 unmask fires v0", 32'(irq), 32'h1);
    wr(8'h10, 32'h1);
  endtask

  task automatic t_merge();
    logic [31:0] d;
    pulse(32'h0021_0000, 32'h0000_0001);
    @(negedge clk); chk("R9 v3 and v2 together", 32'(irq), 32'hC);
    @(negedge clk); chk("R9 one pulse", 32'(irq), 32'h0);
    rd(8'h00, d); chk("R9 merged causes cleared", d, 32'h0);
    rd(8'h08, d); chk("R9 hw cause cleared", d, 32'h0);
    wr(8'h10, 32'hC);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse('0, 32'h2000_0000);
    @(negedge clk); chk("R5 out-of-range no irq", 32'(irq), 32'h0);
    rd(8'h08, d); chk("R5 out-of-range pending", d, 32'h2000_0000);
    @(negedge clk);
    we = 1'b1; addr = 8'h08; wdata = 32'h2000_0000; hw_evt = 32'h2000_0000;
    @(negedge clk);
    we = 1'b0; hw_evt = '0;
    rd(8'h08, d); chk("R3 event beats clear", d, 32'h2000_0000);
    wr(8'h08, 32'h2000_0000);
    rd(8'h08, d); chk("R3 clear alone", d, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_autoclr();
    t_automask();
    t_sticky();
    t_mask();
    t_merge();
    t_race();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule